// File: doc/BRIEF.md
# DSI Command Packet Issuer

This block turns one display-link command into the register traffic that a DSI host controller's packet engine expects. A command header arrives on a valid/ready pair and carries the data type, virtual channel, a low-power request, an acknowledge request, a long/short selector, the payload length and the reply length the caller expects. The payload then arrives one byte per cycle on a second valid/ready stream.

For long packets the bytes are packed into 32-bit words and pushed into an external transmit FIFO. For short packets the first two bytes become the two header parameters, and nothing enters the FIFO. Once the payload is stored, the block writes one packet-control word and then raises a send strobe. It then waits for the link's packet-done indication. A plain write finishes with a completion pulse that reports the payload length. A read that expects a reply is passed on to a reply parser through a hand-over pulse. An overflow or high-speed timeout indication ends the transfer with an error.

Top module: `dsi_cmd_issuer`

## Requirements
- R1: Long-packet payload bytes are written to the FIFO little-endian: the first byte of each group of four goes to bits [7:0], the fourth to bits [31:24]. A final group of 1 to 3 bytes is written as one word with its unused upper bytes zero.
- R2: For a long packet the word count is cmd_len and no byte is lost or added. For a short packet no FIFO write occurs; the first stream byte becomes word-count bits [7:0] and the second becomes bits [15:8]. Bytes that are not supplied read as zero.
- R3: The control word holds the word count in [15:0], the virtual channel in [17:16], the data type in [23:18], high-speed select in [24] and turnaround request in [25]. It is written exactly once per command.
- R4: High-speed select is 1 unless cmd_lp is set, in which case it is 0.
- R5: Turnaround is requested when cmd_ack is set. It is also requested when the data type is 0x04, 0x14, 0x24 (generic reads) or 0x06 (DCS read) and cmd_rx_len is non-zero.
- R6: send_strobe is a single-cycle pulse. It comes in the cycle directly after the control-word write, and every payload word has been written before that.
- R7: On pkt_done for a command without an expected reply, done pulses in the next cycle with err 0 and result equal to cmd_len.
- R8: On pkt_done for a read with an expected reply (R5 read types, cmd_rx_len non-zero), rd_go pulses in the next cycle and done stays low.
- R9: While fifo_full is high during a long packet's payload phase, in_ready is low and no FIFO write occurs.
- R10: A tx_ovf or hs_timeout while waiting for completion pulses done with err 1 and result 0 in the next cycle. This takes priority over a pkt_done in the same cycle, and rd_go stays low.
- R11: After reset, and at all times between commands, cmd_ready is high and in_ready, fifo_wr, ctrl_wr, send_strobe, done and rd_go are low. A long packet with cmd_len 0 issues no FIFO write and a word count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command header valid |
| cmd_ready | output | 1 | Block idle, header accepted |
| cmd_dt | input | 6 | Packet data type |
| cmd_vc | input | 2 | Virtual channel |
| cmd_lp | input | 1 | Request low-power transmission |
| cmd_ack | input | 1 | Request acknowledge (forces turnaround) |
| cmd_long | input | 1 | 1 = long packet, 0 = short packet |
| cmd_len | input | 16 | Payload byte count |
| cmd_rx_len | input | 16 | Expected reply length in bytes |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted |
| in_data | input | 8 | Payload byte |
| fifo_wr | output | 1 | Transmit FIFO write |
| fifo_wdata | output | 32 | Transmit FIFO word |
| fifo_full | input | 1 | Transmit FIFO full |
| ctrl_wr | output | 1 | Control-word write |
| ctrl_word | output | 26 | Packet-control word |
| send_strobe | output | 1 | Start packet transmission |
| pkt_done | input | 1 | Packet sent / reply phase reached |
| tx_ovf | input | 1 | FIFO overflow indication |
| hs_timeout | input | 1 | High-speed transmit timeout |
| done | output | 1 | Transfer finished pulse |
| err | output | 1 | Transfer ended in error (valid with done) |
| result | output | 16 | Byte count reported with done |
| rd_go | output | 1 | Hand over to reply parser |

## Verification
The case that matters most is a completion and an abort arriving together. pkt_done can come in the same cycle as hs_timeout or tx_ovf while the block waits, and the abort must win. The bench provokes this directly by raising pkt_done and hs_timeout on the same edge, for a write and for a read. It judges the outcome at the ports: done with err set and result zero, and no rd_go. A second overlap is a payload byte offered in a cycle when fifo_full is also high. Random full patterns during long packets confirm that such a byte is held back rather than written.

// File: rtl/dsi_cmd_issuer.sv
module dsi_cmd_issuer #(
  parameter int LEN_W = 16,
  parameter int VC_W  = 2,
  parameter int DT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [DT_W-1:0]     cmd_dt,
  input  logic [VC_W-1:0]     cmd_vc,
  input  logic                cmd_lp,
  input  logic                cmd_ack,
  input  logic                cmd_long,
  input  logic [LEN_W-1:0]    cmd_len,
  input  logic [LEN_W-1:0]    cmd_rx_len,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [7:0]          in_data,
  output logic                fifo_wr,
  output logic [31:0]         fifo_wdata,
  input  logic                fifo_full,
  output logic                ctrl_wr,
  output logic [LEN_W+VC_W+DT_W+1:0] ctrl_word,
  output logic                send_strobe,
  input  logic                pkt_done,
  input  logic                tx_ovf,
  input  logic                hs_timeout,
  output logic                done,
  output logic                err,
  output logic [LEN_W-1:0]    result,
  output logic                rd_go
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CTRL, S_SEND, S_WAIT} state_t;

  state_t            st;
  logic [DT_W-1:0]   dt_q;
  logic [VC_W-1:0]   vc_q;
  logic              lp_q, bta_q, rd_q, long_q;
  logic [LEN_W-1:0]  len_q, cnt_q, wc_q;
  logic [1:0]        lane_q;
  logic [31:0]       acc_q;
  logic              done_q, err_q, rdgo_q;
  logic [LEN_W-1:0]  res_q;

  logic        take, last, is_read;
  logic [31:0] word_nx;

  assign is_read = (cmd_dt == DT_W'(6'h04)) || (cmd_dt == DT_W'(6'h14)) ||
                   (cmd_dt == DT_W'(6'h24)) || (cmd_dt == DT_W'(6'h06));

  assign cmd_ready   = (st == S_IDLE);
  assign in_ready    = (st == S_LOAD) && !(long_q && fifo_full);
  assign take        = in_valid && in_ready;
  assign last        = (cnt_q == LEN_W'(1));
  assign word_nx     = acc_q | ({24'd0, in_data} << {lane_q, 3'b000});
  assign fifo_wr     = take && long_q && ((lane_q == 2'd3) || last);
  assign fifo_wdata  = word_nx;
  assign ctrl_wr     = (st == S_CTRL);
  assign ctrl_word   = {bta_q, ~lp_q, dt_q, vc_q, wc_q};
  assign send_strobe = (st == S_SEND);
  assign done        = done_q;
  assign err         = err_q;
  assign result      = res_q;
  assign rd_go       = rdgo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      dt_q   <= '0;
      vc_q   <= '0;
      lp_q   <= 1'b0;
      bta_q  <= 1'b0;
      rd_q   <= 1'b0;
      long_q <= 1'b0;
      len_q  <= '0;
      cnt_q  <= '0;
      wc_q   <= '0;
      lane_q <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rdgo_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      rdgo_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          dt_q   <= cmd_dt;
          vc_q   <= cmd_vc;
          lp_q   <= cmd_lp;
          long_q <= cmd_long;
          rd_q   <= is_read && (cmd_rx_len != '0);
          bta_q  <= cmd_ack || (is_read && (cmd_rx_len != '0));
          len_q  <= cmd_len;
          cnt_q  <= cmd_len;
          wc_q   <= cmd_long ? cmd_len : '0;
          lane_q <= '0;
          acc_q  <= '0;
          st     <= (cmd_len == '0) ? S_CTRL : S_LOAD;
        end
        S_LOAD: if (take) begin
          cnt_q  <= cnt_q - LEN_W'(1);
          lane_q <= lane_q + 2'd1;
          acc_q  <= ((lane_q == 2'd3) || last) ? 32'd0 : word_nx;
          if (!long_q && lane_q == 2'd0 && cnt_q == len_q) wc_q[7:0] <= in_data;
          if (!long_q && lane_q == 2'd1 && cnt_q == len_q - LEN_W'(1)) wc_q[15:8] <= in_data;
          if (last) st <= S_CTRL;
        end
        S_CTRL: st <= S_SEND;
        S_SEND: st <= S_WAIT;
        S_WAIT: begin
          if (tx_ovf || hs_timeout) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            res_q  <= '0;
            st     <= S_IDLE;
          end else if (pkt_done) begin
            if (rd_q) rdgo_q <= 1'b1;
            else begin
              done_q <= 1'b1;
              err_q  <= 1'b0;
              res_q  <= len_q;
            end
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_strobe_after_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    send_strobe |-> $past(ctrl_wr));
  p_ctrl_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !ctrl_wr);
  p_no_write_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);
  p_done_xor_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && rd_go));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !in_ready && !fifo_wr && !send_strobe && !ctrl_wr);
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (result == '0));
  p_no_write_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(1'b1) && long_q);

endmodule

// File: tb/sim_dsi_cmd_issuer.sv
module sim_dsi_cmd_issuer;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, cmd_lp = 0, cmd_ack = 0, cmd_long = 0;
  logic [5:0] cmd_dt = 0;
  logic [1:0] cmd_vc = 0;
  logic [15:0] cmd_len = 0, cmd_rx_len = 0, result;
  logic in_valid = 0, in_ready;
  logic [7:0] in_data = 0;
  logic fifo_wr, fifo_full = 0, ctrl_wr, send_strobe;
  logic [31:0] fifo_wdata;
  logic [25:0] ctrl_word;
  logic pkt_done = 0, tx_ovf = 0, hs_timeout = 0, done, err, rd_go;

  dsi_cmd_issuer u0 (.*);

  int tests = 0, fails = 0, cyc = 0;
  logic [7:0] bytes [0:63];
  logic [31:0] wr_log [0:63];
  int n_wr = 0, last_wr_cyc = -1, ctrl_cyc = -1, n_ctrl = 0, strobe_cyc = -1, n_strobe = 0;
  logic [25:0] ctrl_seen;
  int stall_bad = 0;
  logic stall_mode = 0, cur_long = 0, loading = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_wr) begin wr_log[n_wr % 64] = fifo_wdata; n_wr = n_wr + 1; last_wr_cyc = cyc; end
    if (ctrl_wr) begin ctrl_seen = ctrl_word; ctrl_cyc = cyc; n_ctrl = n_ctrl + 1; end
    if (send_strobe) begin strobe_cyc = cyc; n_strobe = n_strobe + 1; end
    if (fifo_full && loading && cur_long && (in_ready || fifo_wr)) stall_bad = stall_bad + 1;
  end

  always @(negedge clk) fifo_full <= stall_mode ? ($urandom_range(0, 2) == 0) : 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int idx, input int len);
    logic [31:0] w = 0;
    for (int k = 0; k < 4; k++)
      if (idx * 4 + k < len) w[k*8 +: 8] = bytes[idx*4 + k];
    return w;
  endfunction

  function automatic bit is_rd(input logic [5:0] dt);
    return dt == 6'h04 || dt == 6'h14 || dt == 6'h24 || dt == 6'h06;
  endfunction

  // ev: 0 pkt_done, 1 tx_ovf, 2 hs_timeout, 3 pkt_done with hs_timeout
  task automatic run(input logic [5:0] dt, input logic [1:0] vc, input bit lp, input bit ack,
                     input bit lng, input int len, input int rxl, input int ev, input bit stall);
    int w0, s0, c0, i;
    bit rd, bta, acc;
    logic [15:0] wc;
    for (int k = 0; k < len; k++) bytes[k] = 8'($urandom);
    w0 = n_wr; s0 = n_strobe; c0 = n_ctrl;
    @(negedge clk);
    chk(cmd_ready == 1, "R11", "cmd_ready idle", cmd_ready, 1);
    cmd_valid = 1; cmd_dt = dt; cmd_vc = vc; cmd_lp = lp; cmd_ack = ack;
    cmd_long = lng; cmd_len = 16'(len); cmd_rx_len = 16'(rxl);
    cur_long = lng; stall_mode = stall;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; loading = 1;
    i = 0;
    while (i < len) begin
      in_valid = 1; in_data = bytes[i];
      #1 acc = in_ready;
      @(posedge clk);
      if (acc) i++;
      @(negedge clk);
    end
    in_valid = 0; loading = 0; stall_mode = 0;
    while (n_strobe == s0) @(negedge clk);
    rd = is_rd(dt) && rxl != 0;
    bta = ack || rd;
    wc = 0;
    if (lng) wc = 16'(len);
    else begin
      if (len > 0) wc[7:0] = bytes[0];
      if (len > 1) wc[15:8] = bytes[1];
    end
    chk(n_wr - w0 == (lng ? (len + 3) / 4 : 0), "R2", "fifo write count", n_wr - w0, lng ? (len + 3) / 4 : 0);
    if (lng)
      for (int k = 0; k < (len + 3) / 4; k++)
        chk(wr_log[(w0 + k) % 64] == exp_word(k, len), "R1", "packed word", wr_log[(w0 + k) % 64], exp_word(k, len));
    chk(n_ctrl - c0 == 1, "R3", "ctrl writes", n_ctrl - c0, 1);
    chk(ctrl_seen[15:0] == wc, "R2", "word count", ctrl_seen[15:0], wc);
    chk(ctrl_seen[17:16] == vc && ctrl_seen[23:18] == dt, "R3", "vc/dt fields", ctrl_seen[23:16], {dt, vc});
    chk(ctrl_seen[24] == !lp, "R4", "hs select", ctrl_seen[24], !lp);
    chk(ctrl_seen[25] == bta, "R5", "turnaround", ctrl_seen[25], bta);
    chk(strobe_cyc == ctrl_cyc + 1 && n_strobe - s0 == 1 && (n_wr == w0 || last_wr_cyc < ctrl_cyc),
        "R6", "strobe order", strobe_cyc, ctrl_cyc + 1);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    chk(done == 0 && rd_go == 0, "R7", "no early done", done, 0);
    pkt_done = (ev == 0 || ev == 3); tx_ovf = (ev == 1); hs_timeout = (ev == 2 || ev == 3);
    @(negedge clk);
    pkt_done = 0; tx_ovf = 0; hs_timeout = 0;
    if (ev != 0) begin
      chk(done == 1 && err == 1 && result == 0 && rd_go == 0, "R10", "abort", {done, err, rd_go, result}, {3'b110, 16'd0});
    end else if (rd) begin
      chk(rd_go == 1 && done == 0, "R8", "read handoff", {rd_go, done}, 2'b10);
    end else begin
      chk(done == 1 && err == 0 && result == 16'(len) && rd_go == 0, "R7", "write done", {done, err, result}, {2'b10, 16'(len)});
    end
    @(negedge clk);
    chk(done == 0 && rd_go == 0 && cmd_ready == 1, "R11", "back idle", {done, rd_go, cmd_ready}, 3'b001);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] dts [0:7];
    void'($urandom(32'h5eed_1234));
    dts[0] = 6'h39; dts[1] = 6'h29; dts[2] = 6'h05; dts[3] = 6'h15;
    dts[4] = 6'h04; dts[5] = 6'h14; dts[6] = 6'h24; dts[7] = 6'h06;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1 && in_ready == 0 && fifo_wr == 0 && ctrl_wr == 0 && send_strobe == 0 && done == 0 && rd_go == 0,
        "R11", "in reset", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_ready == 1 && in_ready == 0 && done == 0, "R11", "after reset", cmd_ready, 1);
    run(6'h39, 2'd0, 0, 0, 1, 0, 0, 0, 0);   // R11 empty long
    run(6'h39, 2'd1, 0, 0, 1, 1, 0, 0, 0);   // R1 single byte
    run(6'h39, 2'd2, 1, 0, 1, 3, 0, 0, 0);   // R1 R4
    run(6'h29, 2'd3, 0, 0, 1, 4, 0, 0, 0);   // R1 exact word
    run(6'h39, 2'd0, 0, 0, 1, 5, 0, 0, 0);   // R1 spill
    run(6'h05, 2'd0, 0, 0, 0, 1, 0, 0, 0);   // R2 short one param
    run(6'h15, 2'd1, 1, 0, 0, 2, 0, 0, 0);   // R2 short two params
    run(6'h05, 2'd0, 0, 0, 0, 0, 0, 0, 0);   // R2 short no params
    run(6'h06, 2'd0, 1, 0, 0, 1, 2, 0, 0);   // R5 R8 DCS read
    run(6'h06, 2'd0, 1, 0, 0, 1, 0, 0, 0);   // R5 read with empty reply
    run(6'h39, 2'd0, 0, 1, 1, 6, 0, 0, 0);   // R5 ack on write
    run(6'h39, 2'd0, 0, 0, 1, 23, 0, 0, 1);  // R9 stall
    run(6'h39, 2'd0, 0, 0, 1, 8, 0, 1, 0);   // R10 overflow
    run(6'h39, 2'd0, 0, 0, 1, 8, 0, 3, 0);   // R10 same-cycle done and timeout
    run(6'h14, 2'd2, 0, 0, 0, 1, 1, 3, 0);   // R10 read, same cycle
    for (int t = 0; t < 40; t++)
      run(dts[$urandom_range(0, 7)], 2'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0),
          1'($urandom), $urandom_range(0, 40), $urandom_range(0, 2), ($urandom_range(0, 5) == 0) ? 2 : 0,
          1'($urandom));
    chk(stall_bad == 0, "R9", "activity while full", stall_bad, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule